// File: doc/BRIEF.md
# Opcode Fetch Burst Sequencer

This block fetches one script instruction at a time from memory and hands it on as a group of captured 32-bit words. The instruction's length depends on its type, and the type is known only once the first word has arrived. The sequencer therefore issues the fetch as a series of bus ownerships. For each ownership it raises a request that carries an address and a beat count. It waits for a grant, collects the data beats, and then drops the request before it decides whether more words are needed.

When burst mode is enabled for a fetch, the first two words always come in one two-beat ownership. What follows depends on the type:

- A memory-move instruction or an indirect instruction needs one more word, fetched in its own single-beat ownership.
- A table-indirect block move needs two more words, fetched in a second two-beat ownership.

When burst mode is off, every word is a separate single-beat ownership.

An outside decoder reads word 0 from the word outputs and returns the type code on `op_kind`. The sequencer samples that code in the idle cycle that follows each ownership.

Top module: `ofb_fetch_seq`

## Requirements
- R1: While reset is applied, and immediately after it, `bus_req`, `done` and `busy` are all 0.
- R2: A `start` pulse in idle latches `fetch_addr` and `burst_en`, and the first request addresses `fetch_addr`. A `start` while `busy` is 1 is ignored, and the pending request address is unchanged.
- R3: Type code 0 (plain) takes 2 words. With burst on, the first ownership has `bus_len` = 2 at the fetch address, and the instruction completes after that one ownership.
- R4: Type code 2 (memory move) takes 3 words. With burst on, a 2-beat ownership is followed by a separate 1-beat ownership at fetch address + 8.
- R5: Type code 1 (indirect) takes 3 words. With burst on, the extra word is read in a later 1-beat ownership at fetch address + 8.
- R6: Type code 3 (table-indirect block move) takes 4 words. With burst on, they are read as two 2-beat ownerships, at fetch address and at fetch address + 8.
- R7: With burst off, each word i is read in its own ownership with `bus_len` = 1 at fetch address + 4·i.
- R8: `bus_req` stays high, with `bus_addr` and `bus_len` stable, until `bus_gnt`. It is low in the cycle after the grant. It stays low for at least one cycle between two ownerships.
- R9: `done` is a one-cycle pulse. It is raised only after every word for the type has been captured, with `instr_count` equal to the word total. Word i sits at bits [32·i+31:32·i] of `instr_words`, in fetch order, and slots that were not fetched read 0. A `start` in the `done` cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (honoured only when idle) |
| fetch_addr | input | 32 | Byte address of the instruction's first word |
| burst_en | input | 1 | Burst mode for this fetch |
| op_kind | input | 2 | Type code decoded from word 0 (0 plain, 1 indirect, 2 memory move, 3 table-indirect) |
| bus_gnt | input | 1 | Grant for the pending request |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| bus_req | output | 1 | Bus ownership request |
| bus_addr | output | 32 | Start address of the requested access |
| bus_len | output | 2 | Beats in the requested access (1 or 2) |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | Instruction fully captured (one cycle) |
| instr_count | output | 3 | Words captured in the current fetch |
| instr_words | output | 128 | Captured words, word 0 in the low bits |

## Verification
Completion of one fetch and the launch of the next can land in the same cycle: a `start` may arrive exactly while `done` is high. The bench raises `start` in that cycle with a new address in directed cases. It then requires that no request follows and that `busy` is low one cycle later. Grant and request can also meet in the first cycle of a request, because a random wait of zero is allowed. In that case the bench requires the request to be dropped on the next cycle and the beats to be captured normally.

// File: rtl/ofb_pkg.sv
package ofb_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN    = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_MEMMOVE  = 2'd2,
    KIND_TABLE    = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_GAP
  } seq_state_e;

  localparam int unsigned MAX_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(MAX_WORDS + 1);

  // Words that an instruction of the given type occupies.
  function automatic logic [IDX_W-1:0] words_for_kind(op_kind_e k);
    case (k)
      KIND_PLAIN:    words_for_kind = IDX_W'(2);
      KIND_INDIRECT: words_for_kind = IDX_W'(3);
      KIND_MEMMOVE:  words_for_kind = IDX_W'(3);
      default:       words_for_kind = IDX_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/ofb_beat_plan.sv
// Beat count of the next ownership: a two-beat burst starts only on an
// even word index with at least two words left; everything else is single.
module ofb_beat_plan #(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] total_i,
  input  logic             burst_i,
  output logic [1:0]       beats_o
);
  logic [IDX_W-1:0] left;

  always_comb begin
    left = total_i - idx_i;
    if (burst_i && !idx_i[0] && (left >= IDX_W'(2))) beats_o = 2'd2;
    else                                              beats_o = 2'd1;
  end
endmodule

// File: rtl/ofb_addr_gen.sv
module ofb_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned BYTES = DATA_W / 8;

  assign addr_o = base_i + (ADDR_W'(idx_i) * ADDR_W'(BYTES));
endmodule

// File: rtl/ofb_word_store.sv
module ofb_word_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic [WORDS*DATA_W-1:0] words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              hit;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (clr_i) slot_q <= '0;
      else if (hit)   slot_q <= wr_data_i;
    end

    assign words_o[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/ofb_fetch_seq.sv
module ofb_fetch_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [ADDR_W-1:0]                     fetch_addr,
  input  logic                                  burst_en,
  input  logic [1:0]                            op_kind,
  input  logic                                  bus_gnt,
  input  logic                                  rd_valid,
  input  logic [DATA_W-1:0]                     rd_data,
  output logic                                  bus_req,
  output logic [ADDR_W-1:0]                     bus_addr,
  output logic [1:0]                            bus_len,
  output logic                                  busy,
  output logic                                  done,
  output logic [ofb_pkg::IDX_W-1:0]             instr_count,
  output logic [ofb_pkg::MAX_WORDS*DATA_W-1:0]  instr_words
);
  import ofb_pkg::*;

  localparam int unsigned WORDS = MAX_WORDS;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              burst_q, burst_d;
  op_kind_e          kind_q, kind_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        left_q, left_d;

  logic [IDX_W-1:0]  total_q, total_in;
  logic [1:0]        plan_beats;
  logic              take_start, take_beat, finish;

  assign total_q  = words_for_kind(kind_q);
  assign total_in = words_for_kind(op_kind_e'(op_kind));

  assign take_start = start && (state_q == ST_IDLE);
  assign take_beat  = rd_valid && (state_q == ST_DATA);
  assign finish     = (state_q == ST_GAP) && (idx_q == total_in);

  ofb_beat_plan #(.IDX_W(IDX_W)) plan_i (
    .idx_i   (idx_q),
    .total_i (total_q),
    .burst_i (burst_q),
    .beats_o (plan_beats)
  );

  ofb_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) addr_i (
    .base_i (base_q),
    .idx_i  (idx_q),
    .addr_o (bus_addr)
  );

  ofb_word_store #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (take_start),
    .wr_en_i   (take_beat),
    .wr_idx_i  (idx_q),
    .wr_data_i (rd_data),
    .words_o   (instr_words)
  );

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    burst_d = burst_q;
    kind_d  = kind_q;
    idx_d   = idx_q;
    left_d  = left_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_REQ;
          base_d  = fetch_addr;
          burst_d = burst_en;
          kind_d  = KIND_PLAIN;   // assume the shortest length until word 0 is decoded
          idx_d   = '0;
        end
      end
      ST_REQ: begin
        if (bus_gnt) begin
          state_d = ST_DATA;
          left_d  = plan_beats;
        end
      end
      ST_DATA: begin
        if (rd_valid) begin
          idx_d  = idx_q + IDX_W'(1);
          left_d = left_q - 2'd1;
          if (left_q == 2'd1) state_d = ST_GAP;
        end
      end
      default: begin           // ST_GAP: request released, type now known
        kind_d  = op_kind_e'(op_kind);
        state_d = finish ? ST_IDLE : ST_REQ;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      burst_q <= 1'b0;
      kind_q  <= KIND_PLAIN;
      idx_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      burst_q <= burst_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      left_q  <= left_d;
    end
  end

  assign bus_req     = (state_q == ST_REQ);
  assign bus_len     = plan_beats;
  assign busy        = (state_q != ST_IDLE);
  assign done        = finish;
  assign instr_count = idx_q;

endmodule

// File: rtl/ofb_fetch_seq_chk.sv
module ofb_fetch_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_len,
  input logic              busy,
  input logic              done,
  input logic              burst_mode
);
  // R8: request held with stable address and length until granted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_len));

  // R8: request released in the cycle after a grant
  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> !bus_req);

  // R3: only one- or two-beat accesses are ever requested
  assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_len == 2'd1 || bus_len == 2'd2));

  // R7: without burst mode every access is single-beat
  assert_single_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !burst_mode |-> bus_len == 2'd1);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion only while a fetch is active and no request is pending
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !bus_req);
endmodule

bind ofb_fetch_seq ofb_fetch_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_addr   (bus_addr),
  .bus_len    (bus_len),
  .busy       (busy),
  .done       (done),
  .burst_mode (burst_q)
);

// File: tb/ofb_fetch_seq_tb.sv
`timescale 1ns/1ps
module ofb_fetch_seq_tb_top;
  logic         clk;
  logic         rst_n;
  logic         start;
  logic [31:0]  fetch_addr;
  logic         burst_en;
  logic [1:0]   op_kind;
  logic         bus_gnt;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         bus_req;
  logic [31:0]  bus_addr;
  logic [1:0]   bus_len;
  logic         busy;
  logic         done;
  logic [2:0]   instr_count;
  logic [127:0] instr_words;

  int n_chk  = 0;
  int n_fail = 0;

  ofb_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_addr(fetch_addr),
    .burst_en(burst_en), .op_kind(op_kind), .bus_gnt(bus_gnt),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_len(bus_len), .busy(busy), .done(done),
    .instr_count(instr_count), .instr_words(instr_words)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_words(input logic [1:0] k);
    case (k)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_beats(input bit burst, input int idx, input int total);
    if (!burst) return 1;                      // R7
    if (idx == 0) return 2;                    // R3: first two words in one burst
    if (total - idx >= 2) return 2;            // R6: table-indirect second burst
    return 1;                                  // R4/R5: separate single word
  endfunction

  function automatic string kind_tag(input logic [1:0] k, input bit burst);
    if (!burst) return "R7";
    case (k)
      2'd0:    return "R3";
      2'd1:    return "R5";
      2'd2:    return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic do_fetch(input logic [31:0] addr, input logic [1:0] k, input bit burst,
                          input bit poke_busy, input bit poke_done);
    logic [31:0] got [4];
    int idx, total, len;
    string tg;
    for (int i = 0; i < 4; i++) got[i] = '0;
    tg = kind_tag(k, burst);
    total = exp_words(k);
    @(negedge clk);
    start = 1'b1; fetch_addr = addr; burst_en = burst; op_kind = k;
    @(negedge clk);
    start = 1'b0; fetch_addr = ~addr; burst_en = ~burst;   // latched values must be used (R2)
    idx = 0;
    while (idx < total) begin
      len = exp_beats(burst, idx, total);
      chk(bus_req == 1'b1, "R8 request raised", 64'(bus_req), 64'd1);
      chk(bus_addr == addr + 32'(4 * idx), (idx == 0) ? "R2 first address" : tg, 64'(bus_addr), 64'(addr + 32'(4 * idx)));
      chk(bus_len == 2'(len), tg, 64'(bus_len), 64'(len));
      if (poke_busy && idx == 0) begin
        start = 1'b1; fetch_addr = 32'hDEAD_0000;
        @(negedge clk);
        start = 1'b0;
        chk(bus_addr == addr, "R2 start while busy ignored", 64'(bus_addr), 64'(addr));
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
      chk(bus_req && bus_addr == addr + 32'(4 * idx) && bus_len == 2'(len),
          "R8 held until grant", 64'(bus_addr), 64'(addr + 32'(4 * idx)));
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      chk(!bus_req, "R8 release after grant", 64'(bus_req), 64'd0);
      for (int b = 0; b < len; b++) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = $urandom;
        got[idx] = rd_data;
        idx++;
        @(negedge clk);
        rd_valid = 1'b0;
      end
      chk(!bus_req, "R8 gap between ownerships", 64'(bus_req), 64'd0);
      chk(done == (idx == total), "R9 done timing", 64'(done), 64'(idx == total));
      if (idx == total) begin
        chk(instr_count == 3'(total), "R9 word count", 64'(instr_count), 64'(total));
        for (int i = 0; i < 4; i++)
          chk(instr_words[i*32 +: 32] == ((i < total) ? got[i] : 32'd0), "R9 word content",
              64'(instr_words[i*32 +: 32]), 64'((i < total) ? got[i] : 32'd0));
        if (poke_done) begin
          start = 1'b1; fetch_addr = 32'hBEEF_0000;
          @(negedge clk);
          start = 1'b0;
          chk(!busy && !bus_req, "R9 start in done cycle ignored", 64'({busy, bus_req}), 64'd0);
        end else begin
          @(negedge clk);
        end
        chk(!busy && !done, "R9 idle after done", 64'({busy, done}), 64'd0);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0FB5_1234));
    rst_n = 1'b0; start = 1'b0; fetch_addr = '0; burst_en = 1'b0; op_kind = '0;
    bus_gnt = 1'b0; rd_valid = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !done && !busy, "R1 reset state", 64'({bus_req, done, busy}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req && !done && !busy, "R1 after release", 64'({bus_req, done, busy}), 64'd0);

    // directed: each type with burst on and off
    do_fetch(32'h0000_1000, 2'd0, 1'b1, 1'b0, 1'b0);   // R3
    do_fetch(32'h0000_2000, 2'd2, 1'b1, 1'b0, 1'b0);   // R4
    do_fetch(32'h0000_3000, 2'd1, 1'b1, 1'b0, 1'b0);   // R5
    do_fetch(32'h0000_4000, 2'd3, 1'b1, 1'b0, 1'b0);   // R6
    do_fetch(32'h0000_5000, 2'd3, 1'b0, 1'b0, 1'b0);   // R7
    do_fetch(32'h0000_6000, 2'd2, 1'b0, 1'b0, 1'b0);   // R7
    // directed: start while busy, start in the done cycle
    do_fetch(32'h0000_7000, 2'd1, 1'b1, 1'b1, 1'b1);   // R2, R9
    do_fetch(32'h0000_8000, 2'd0, 1'b0, 1'b1, 1'b1);   // R2, R9

    for (int n = 0; n < 40; n++)
      do_fetch({$urandom_range(0, 32'h00FF_FFFF), 2'b00}, 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule